// File: doc/BRIEF.md
# USB Descriptor Memory Access Gate

This block sits between a local CPU register bus and the byte-wide descriptor store of a USB device controller. It decides when the CPU may read or write the store. It follows the window in which a host SET_DESCRIPTOR request is being serviced. It can answer that request with an automatic STALL. It also tells the device core when to pick up fresh descriptor contents.

The CPU has free access to the store until the first USB bus reset is seen. After that, access is granted only inside a SET_DESCRIPTOR window. The window opens on a setup event flagged as SET_DESCRIPTOR. It closes when the CPU touches the end-of-packet (EOP) register, and a later status-done event then produces a completion pulse. A load pulse goes to the device core after every bus reset and after every reinitialise command. Triggers that overlap are merged into a single pulse.

Top module: `desc_ram_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `stall_out`, `desc_load`, `set_desc_done` and `cpu_rdata` are all 0.
- R2: The store holds 384 bytes at CPU addresses 0x500 to 0x67F (address minus 0x500 selects the byte). Read data appears on `cpu_rdata` in the cycle after the read strobe and holds until the next read. Before the first bus reset, every location can be written and read back.
- R3: After the first bus reset and outside the SET_DESCRIPTOR window, store writes are ignored and reads return 0x00. A read of any address outside 0x500 to 0x67F always returns 0x00.
- R4: The window opens in the cycle after `setup_evt` is high with `setup_is_setdesc` = 1. A setup event with `setup_is_setdesc` = 0 does not open it.
- R5: The window closes in the cycle after a read or write strobe at the EOP address 0x7EC. A bus reset also closes it.
- R6: The auto-STALL control is bit 0 of a write-only register at 0x7E8. It resets to 0, and reads of 0x7E8 return 0x00. `stall_out` is high exactly when this bit is 1 and the window is open.
- R7: A bus reset event makes `desc_load` high for one cycle, in the cycle after the event.
- R8: A write of 0x01 to the command register at 0x7E4 makes `desc_load` high for one cycle, in the cycle after the write. A write of any other value does not.
- R9: A trigger that arrives while `desc_load` is high is merged into that pulse. Two triggers in the same cycle give one pulse, so `desc_load` is never high for two cycles in a row.
- R10: `set_desc_done` pulses for one cycle after `status_done_evt`, but only the first such event after an EOP access has closed the window. Status-done events at other times are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 12 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Registered read data |
| bus_reset_evt | input | 1 | USB bus reset detected (one-cycle event) |
| setup_evt | input | 1 | Setup packet received (one-cycle event) |
| setup_is_setdesc | input | 1 | The setup event carries a SET_DESCRIPTOR request |
| status_done_evt | input | 1 | Status stage finished (one-cycle event) |
| stall_out | output | 1 | Automatic STALL request to the endpoint logic |
| desc_load | output | 1 | One-cycle descriptor load request to the device core |
| set_desc_done | output | 1 | One-cycle completion of a SET_DESCRIPTOR exchange |

## Verification
The bench uses the first and last bytes of the store to expose an off-by-one in the range decode. A wrong decode would lose 0x67F or alias 0x680 onto the store. After the first bus reset it writes a byte outside the window and then reads it inside a window. A gate that only blanked reads would show the overwritten value there. Load triggers are stacked back to back and also in the same cycle; a missing merge shows up as a two-cycle `desc_load`. Status-done events are sent twice and also with no prior EOP access, to catch a completion pulse that is not tied to the window closing.

// File: rtl/desc_ctl_pkg.sv
package desc_ctl_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 8;
    localparam int MEM_DEPTH = 384;
    localparam int IDX_W     = $clog2(MEM_DEPTH);

    localparam logic [ADDR_W-1:0] MEM_BASE   = 12'h500;
    localparam logic [ADDR_W-1:0] MEM_LAST   = MEM_BASE + ADDR_W'(MEM_DEPTH - 1);
    localparam logic [ADDR_W-1:0] CMD_ADDR   = 12'h7E4;
    localparam logic [ADDR_W-1:0] STALL_ADDR = 12'h7E8;
    localparam logic [ADDR_W-1:0] EOP_ADDR   = 12'h7EC;
    localparam logic [DATA_W-1:0] CMD_INIT   = 8'h01;

    typedef enum logic [1:0] {
        WIN_IDLE,
        WIN_OPEN,
        WIN_WAIT_STS
    } win_state_e;

    typedef struct packed {
        logic             mem_hit;
        logic             cmd_hit;
        logic             stall_hit;
        logic             eop_hit;
        logic [IDX_W-1:0] idx;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.mem_hit   = (a >= MEM_BASE) && (a <= MEM_LAST);
        d.cmd_hit   = (a == CMD_ADDR);
        d.stall_hit = (a == STALL_ADDR);
        d.eop_hit   = (a == EOP_ADDR);
        d.idx       = IDX_W'(a - MEM_BASE);
        return d;
    endfunction
endpackage

// File: rtl/desc_store.sv
module desc_store #(
    parameter int DEPTH = 384,
    parameter int DW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_strobe,
    input  logic          rd_ok,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_strobe)
            rdata <= rd_ok ? mem[idx] : '0;
    end
endmodule

// File: rtl/desc_window.sv
module desc_window
    import desc_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic setup_sd,
    input  logic eop_access,
    input  logic status_done,
    output logic win_open,
    output logic reset_seen,
    output logic sd_done
);
    win_state_e state_q, state_d;
    logic       done_d;

    always_comb begin
        state_d = state_q;
        done_d  = 1'b0;
        if (bus_reset) begin
            state_d = WIN_IDLE;
        end else if (setup_sd) begin
            state_d = WIN_OPEN;
        end else begin
            unique case (state_q)
                WIN_OPEN:     if (eop_access) state_d = WIN_WAIT_STS;
                WIN_WAIT_STS: if (status_done) begin
                                  state_d = WIN_IDLE;
                                  done_d  = 1'b1;
                              end
                default:      state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WIN_IDLE;
            reset_seen <= 1'b0;
            sd_done    <= 1'b0;
        end else begin
            state_q    <= state_d;
            sd_done    <= done_d;
            if (bus_reset)
                reset_seen <= 1'b1;
        end
    end

    assign win_open = (state_q == WIN_OPEN);
endmodule

// File: rtl/desc_load_gen.sv
module desc_load_gen #(
    parameter int N_TRIG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIG-1:0] trig,
    output logic              load
);
    always_ff @(posedge clk) begin
        if (rst)
            load <= 1'b0;
        else
            load <= (|trig) && !load;
    end
endmodule

// File: rtl/desc_ram_ctrl.sv
module desc_ram_ctrl
    import desc_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              bus_reset_evt,
    input  logic              setup_evt,
    input  logic              setup_is_setdesc,
    input  logic              status_done_evt,
    output logic              stall_out,
    output logic              desc_load,
    output logic              set_desc_done
);
    addr_dec_t dec;
    logic      win_open;
    logic      reset_seen;
    logic      acc_ok;
    logic      stall_en;
    logic      init_cmd;

    assign dec      = decode_addr(cpu_addr);
    assign acc_ok   = !reset_seen || win_open;
    assign init_cmd = cpu_wr && dec.cmd_hit && (cpu_wdata == CMD_INIT);

    desc_store #(.DEPTH(MEM_DEPTH), .DW(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cpu_wr && dec.mem_hit && acc_ok),
        .rd_strobe (cpu_rd),
        .rd_ok     (dec.mem_hit && acc_ok),
        .idx       (dec.idx),
        .wdata     (cpu_wdata),
        .rdata     (cpu_rdata)
    );

    desc_window u_win (
        .clk         (clk),
        .rst         (rst),
        .bus_reset   (bus_reset_evt),
        .setup_sd    (setup_evt && setup_is_setdesc),
        .eop_access  ((cpu_rd || cpu_wr) && dec.eop_hit),
        .status_done (status_done_evt),
        .win_open    (win_open),
        .reset_seen  (reset_seen),
        .sd_done     (set_desc_done)
    );

    desc_load_gen #(.N_TRIG(2)) u_load (
        .clk  (clk),
        .rst  (rst),
        .trig ({init_cmd, bus_reset_evt}),
        .load (desc_load)
    );

    always_ff @(posedge clk) begin
        if (rst)
            stall_en <= 1'b0;
        else if (cpu_wr && dec.stall_hit)
            stall_en <= cpu_wdata[0];
    end

    assign stall_out = stall_en && win_open;
endmodule

// File: rtl/desc_ram_ctrl_chk.sv
module desc_ram_ctrl_chk
    import desc_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              bus_reset_evt,
    input logic              setup_evt,
    input logic              status_done_evt,
    input logic              stall_out,
    input logic              desc_load,
    input logic              set_desc_done,
    input logic              acc_ok
);
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(cpu_rdata));

    assert_blocked_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && !acc_ok) |=> (cpu_rdata == '0));

    assert_eop_clears_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (stall_out && (cpu_rd || cpu_wr) && cpu_addr == EOP_ADDR && !setup_evt) |=> !stall_out);

    assert_stall_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_out) |-> ($past(setup_evt) || $past(cpu_wr && cpu_addr == STALL_ADDR)));

    assert_bus_reset_load_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_reset_evt && !desc_load) |=> desc_load);

    assert_load_single_R9: assert property (@(posedge clk) disable iff (rst)
        desc_load |=> !desc_load);

    assert_done_cause_R10: assert property (@(posedge clk) disable iff (rst)
        set_desc_done |-> $past(status_done_evt));
endmodule

bind desc_ram_ctrl desc_ram_ctrl_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cpu_addr        (cpu_addr),
    .cpu_rd          (cpu_rd),
    .cpu_wr          (cpu_wr),
    .cpu_rdata       (cpu_rdata),
    .bus_reset_evt   (bus_reset_evt),
    .setup_evt       (setup_evt),
    .status_done_evt (status_done_evt),
    .stall_out       (stall_out),
    .desc_load       (desc_load),
    .set_desc_done   (set_desc_done),
    .acc_ok          (acc_ok)
);

// File: tb/desc_ram_ctrl_tb.sv
module desc_ram_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_rdata;
    logic        bus_reset_evt, setup_evt, setup_is_setdesc, status_done_evt;
    logic        stall_out, desc_load, set_desc_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    desc_ram_ctrl u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .bus_reset_evt(bus_reset_evt), .setup_evt(setup_evt),
        .setup_is_setdesc(setup_is_setdesc), .status_done_evt(status_done_evt),
        .stall_out(stall_out), .desc_load(desc_load), .set_desc_done(set_desc_done)
    );

    // {address, data} pairs written before the first bus reset, then read back
    localparam int NVEC = 8;
    localparam logic [19:0] VEC [NVEC] = '{
        {12'h500, 8'h3C}, {12'h501, 8'hC3}, {12'h57F, 8'h11}, {12'h5FF, 8'h80},
        {12'h600, 8'h7E}, {12'h640, 8'h01}, {12'h67E, 8'hFF}, {12'h67F, 8'h5A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic ev_bus_reset();
        @(negedge clk); bus_reset_evt = 1'b1;
        @(negedge clk); bus_reset_evt = 1'b0;
    endtask

    task automatic ev_setup(input logic is_sd);
        @(negedge clk); setup_evt = 1'b1; setup_is_setdesc = is_sd;
        @(negedge clk); setup_evt = 1'b0; setup_is_setdesc = 1'b0;
    endtask

    task automatic ev_status();
        @(negedge clk); status_done_evt = 1'b1;
        @(negedge clk); status_done_evt = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        rst = 1'b1; cpu_addr = '0; cpu_wdata = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        bus_reset_evt = 1'b0; setup_evt = 1'b0; setup_is_setdesc = 1'b0; status_done_evt = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 stall in reset", stall_out, 0);
        check("R1 load in reset", desc_load, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 stall", stall_out, 0);
        check("R1 load", desc_load, 0);
        check("R1 done", set_desc_done, 0);
        check("R1 rdata", cpu_rdata, 0);

        // R2: free access before the first bus reset, table walk
        for (int i = 0; i < NVEC; i++) cpu_write(VEC[i][19:8], VEC[i][7:0]);
        for (int i = 0; i < NVEC; i++) begin
            cpu_read(VEC[i][19:8], rd);
            check("R2 readback", rd, VEC[i][7:0]);
        end
        cpu_read(12'h680, rd);
        check("R3 beyond last byte", rd, 0);
        cpu_read(12'h7E8, rd);
        check("R6 stall reg write-only", rd, 0);

        // R7: bus reset gives a one-cycle load pulse
        ev_bus_reset();
        check("R7 load pulse", desc_load, 1);
        @(negedge clk);
        check("R7 load one cycle", desc_load, 0);

        // R3: blocked outside window
        cpu_write(12'h500, 8'hEE);
        cpu_read(12'h500, rd);
        check("R3 blocked read", rd, 0);

        // R4: non-SET_DESCRIPTOR setup keeps the gate shut
        ev_setup(1'b0);
        cpu_read(12'h501, rd);
        check("R4 other setup", rd, 0);

        // R6: enable auto-stall while the window is closed
        cpu_write(12'h7E8, 8'h01);
        check("R6 stall needs window", stall_out, 0);
        ev_setup(1'b1);
        check("R6 stall in window", stall_out, 1);
        cpu_read(12'h500, rd);
        check("R3 blocked write ignored", rd, 8'h3C);
        cpu_write(12'h510, 8'h96);
        cpu_read(12'h510, rd);
        check("R4 window write", rd, 8'h96);
        cpu_read(12'h67F, rd);
        check("R4 window last byte", rd, 8'h5A);
        ev_status();
        check("R10 status while open", set_desc_done, 0);

        // R5: EOP access closes the window
        cpu_write(12'h7EC, 8'h00);
        check("R5 stall drops on EOP", stall_out, 0);
        cpu_read(12'h510, rd);
        check("R5 closed read", rd, 0);

        // R10: completion pulse only once
        ev_status();
        check("R10 done pulse", set_desc_done, 1);
        @(negedge clk);
        check("R10 done one cycle", set_desc_done, 0);
        ev_status();
        check("R10 second status ignored", set_desc_done, 0);

        // R8: reinitialise command
        cpu_write(12'h7E4, 8'h02);
        check("R8 other command", desc_load, 0);
        cpu_write(12'h7E4, 8'h01);
        check("R8 init pulse", desc_load, 1);
        @(negedge clk);
        check("R8 init one cycle", desc_load, 0);

        // R9: back-to-back triggers merge
        @(negedge clk); bus_reset_evt = 1'b1;
        @(negedge clk);
        check("R9 first pulse", desc_load, 1);
        @(negedge clk); bus_reset_evt = 1'b0;
        check("R9 merged", desc_load, 0);
        @(negedge clk);
        check("R9 idle", desc_load, 0);
        @(negedge clk); bus_reset_evt = 1'b1; cpu_addr = 12'h7E4; cpu_wdata = 8'h01; cpu_wr = 1'b1;
        @(negedge clk); bus_reset_evt = 1'b0; cpu_wr = 1'b0;
        check("R9 same-cycle pulse", desc_load, 1);
        @(negedge clk);
        check("R9 same-cycle single", desc_load, 0);

        // R5: bus reset inside window closes it
        ev_setup(1'b1);
        check("R5 reopened", stall_out, 1);
        ev_bus_reset();
        check("R5 bus reset closes", stall_out, 0);
        cpu_read(12'h500, rd);
        check("R5 closed by bus reset", rd, 0);

        // R6: auto-stall off keeps stall low in window
        cpu_write(12'h7E8, 8'h00);
        ev_setup(1'b1);
        check("R6 stall disabled", stall_out, 0);
        cpu_read(12'h501, rd);
        check("R4 window read", rd, 8'hC3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule